// File: doc/BRIEF.md
# I2C Register Target with Clock Snapshot

This block connects an external I2C controller to a 32-byte register space. It oversamples the raw SCL and SDA lines with the system clock and rejects short glitches on them. From the cleaned lines it finds START, repeated START and STOP. It then decodes the device identifier, ACKs the bytes it accepts, and pulls SDA low only as an open-drain output. A register pointer selects the location for every transfer. The pointer advances after each byte, wraps from the top of the space back to zero, and keeps its value between transactions.

On the back end, a write is a one-cycle strobe carrying the address and the data. A read is a one-cycle strobe whose data is expected one clock later. The lowest locations hold the time-of-day bytes, which come in on a parallel input. When a read transaction begins, the block copies these bytes into a local buffer. Every read of those locations in that transaction returns the copy, so a clock tick partway through a read cannot tear the time. At a STOP, two pulses tell the neighbouring logic how the transaction ended. One says data was written, which lets the clock start. The other says data was read, which drives the flag auto-clear.

Top module: `i2c_regport`

## Requirements
- R1: The first byte after a START carries the device identifier 1101111 in bits 7..1 and the direction in bit 0 (1 = read, 0 = write). All bytes travel MSB first. A matching identifier is ACKed: the block holds SDA low through the ninth SCL pulse.
- R2: A byte with any other identifier is not ACKed. Until the next START the block then ignores the bus: it issues no strobes, leaves the pointer unchanged and never drives SDA.
- R3: In a write, the byte after the identifier is the register address and is ACKed. Each later byte is ACKed and produces exactly one write strobe carrying the current pointer and that byte.
- R4: The pointer advances by one after each data byte written or read, and wraps from 31 to 0.
- R5: The pointer is 0 after reset and holds its value across transactions. A read with no address phase starts at the last pointer value.
- R6: A random read is a write of the identifier and the address, then a repeated START and the identifier with the read bit set. The returned bytes start at that address.
- R7: During a read, the block sends the next byte for as long as the controller ACKs the ninth pulse. After a NACK the block releases SDA and stays released until the next START or STOP.
- R8: At the start of each read transaction, the block copies the NUM_TIME time bytes (byte k at time_i[8k+7:8k]). Reads of addresses below NUM_TIME return this copy, not the live input.
- R9: A level on SCL or SDA that lasts fewer than FILT_CYC clocks (6 by default) has no effect on the transfer.
- R10: At a STOP, wr_done_o pulses for one cycle if the transaction wrote at least one data byte. rd_done_o pulses if it read at least one byte. An address-only write phase produces neither pulse.
- R11: After reset, SDA is released and all strobes and pulses are low.
- R12: The block changes its SDA drive only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Raw SCL line level |
| sda_i | input | 1 | Raw SDA line level (wired bus value) |
| sda_oe_o | output | 1 | 1 pulls SDA low, 0 releases it |
| reg_addr_o | output | ADDR_W (5) | Register address for a write or read strobe |
| reg_wr_o | output | 1 | One-cycle write strobe |
| reg_wdata_o | output | 8 | Write data |
| reg_rd_o | output | 1 | One-cycle read strobe |
| reg_rdata_i | input | 8 | Read data, valid one clock after reg_rd_o |
| time_i | input | NUM_TIME*8 (56) | Live time bytes, byte k at bits 8k+7..8k |
| wr_done_o | output | 1 | Pulse at STOP after a write carrying data |
| rd_done_o | output | 1 | Pulse at STOP after a read |

## Verification
The bench first writes all 32 locations in one page write that starts at 5 and wraps through 31. It then reads 33 bytes in sequence across the wrap. A pointer that saturated or failed to wrap would put data in the wrong places and misread the sweep. Short reads after each transaction check that the pointer persists. This applies in particular after a rejected identifier: a design that acted on a non-matching byte would ACK it or move the pointer. The time input is changed partway through a read. A design with no snapshot would return the new bytes, and one that never refreshed the copy would return stale bytes on the next read. Glitches shorter than the filter window are injected on SCL while it is low and on SDA while SCL is high. If either passed the filter, it would add a bit or fake a START or STOP, and the write would go to the wrong place.

// File: rtl/i2c_regport_pkg.sv
package i2c_regport_pkg;
  typedef enum logic [3:0] {
    ST_IDLE,
    ST_DEV,
    ST_REG,
    ST_WR,
    ST_ACK_DEV,
    ST_ACK_REG,
    ST_ACK_WR,
    ST_TX,
    ST_TX_ACK,
    ST_SKIP
  } tgt_state_e;
endpackage

// File: rtl/i2c_deglitch.sv
module i2c_deglitch #(
  parameter int FILT_CYC = 6
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  localparam int CW = $clog2(FILT_CYC + 1);

  logic [1:0]    sync_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= 2'b11;
      dout   <= 1'b1;
      cnt_q  <= '0;
    end else begin
      sync_q <= {sync_q[0], din};
      if (sync_q[1] != dout) begin
        if (cnt_q == CW'(FILT_CYC - 1)) begin
          dout  <= sync_q[1];
          cnt_q <= '0;
        end else begin
          cnt_q <= cnt_q + CW'(1);
        end
      end else begin
        cnt_q <= '0;
      end
    end
  end

  // R9: the filtered level only ever moves to the synchronized input level
  a_r9_filter_follows: assert property (@(posedge clk) disable iff (rst)
    !$stable(dout) |-> (dout == $past(sync_q[1])));
endmodule

// File: rtl/i2c_cond_det.sv
module i2c_cond_det (
  input  logic clk,
  input  logic rst,
  input  logic scl,
  input  logic sda,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_evt,
  output logic stop_evt
);
  logic scl_q, sda_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl;
      sda_q <= sda;
    end
  end

  assign scl_rise  = scl & ~scl_q;
  assign scl_fall  = ~scl & scl_q;
  assign start_evt = scl & scl_q & sda_q & ~sda;
  assign stop_evt  = scl & scl_q & ~sda_q & sda;
endmodule

// File: rtl/i2c_time_snap.sv
module i2c_time_snap #(
  parameter int NUM_TIME = 7,
  parameter int ADDR_W   = 5
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  cap,
  input  logic [NUM_TIME*8-1:0] time_i,
  input  logic [ADDR_W-1:0]     sel,
  output logic                  hit,
  output logic [7:0]            dout
);
  logic [7:0] snap_q [NUM_TIME];

  for (genvar k = 0; k < NUM_TIME; k++) begin : g_byte
    always_ff @(posedge clk) begin
      if (rst)      snap_q[k] <= '0;
      else if (cap) snap_q[k] <= time_i[8*k +: 8];
    end
  end

  always_comb begin
    hit  = 1'b0;
    dout = '0;
    for (int k = 0; k < NUM_TIME; k++) begin
      if (sel == ADDR_W'(k)) begin
        hit  = 1'b1;
        dout = snap_q[k];
      end
    end
  end
endmodule

// File: rtl/i2c_regport.sv
module i2c_regport
  import i2c_regport_pkg::*;
#(
  parameter logic [6:0] DEV_ID   = 7'b1101111,
  parameter int         ADDR_W   = 5,
  parameter int         NUM_TIME = 7,
  parameter int         FILT_CYC = 6
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  scl_i,
  input  logic                  sda_i,
  output logic                  sda_oe_o,
  output logic [ADDR_W-1:0]     reg_addr_o,
  output logic                  reg_wr_o,
  output logic [7:0]            reg_wdata_o,
  output logic                  reg_rd_o,
  input  logic [7:0]            reg_rdata_i,
  input  logic [NUM_TIME*8-1:0] time_i,
  output logic                  wr_done_o,
  output logic                  rd_done_o
);
  localparam int NLINE = 2;

  logic [NLINE-1:0] raw_w, filt_w;
  logic scl_f, sda_f;
  logic scl_rise, scl_fall, start_e, stop_e;

  assign raw_w = {sda_i, scl_i};

  for (genvar gi = 0; gi < NLINE; gi++) begin : g_filt
    i2c_deglitch #(.FILT_CYC(FILT_CYC)) u_filt (
      .clk (clk),
      .rst (rst),
      .din (raw_w[gi]),
      .dout(filt_w[gi])
    );
  end

  assign scl_f = filt_w[0];
  assign sda_f = filt_w[1];

  i2c_cond_det u_cond (
    .clk      (clk),
    .rst      (rst),
    .scl      (scl_f),
    .sda      (sda_f),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start_evt(start_e),
    .stop_evt (stop_e)
  );

  logic       snap_cap, snap_hit;
  logic [7:0] snap_byte;

  i2c_time_snap #(.NUM_TIME(NUM_TIME), .ADDR_W(ADDR_W)) u_snap (
    .clk   (clk),
    .rst   (rst),
    .cap   (snap_cap),
    .time_i(time_i),
    .sel   (reg_addr_o),
    .hit   (snap_hit),
    .dout  (snap_byte)
  );

  tgt_state_e        state;
  logic [7:0]        rx_sh, tx_sh, tx_next;
  logic [3:0]        bitc;
  logic [ADDR_W-1:0] ptr;
  logic              rw_q, m_ack, wrote, readb, rd_cap;

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_IDLE;
      rx_sh       <= '0;
      tx_sh       <= '0;
      tx_next     <= '0;
      bitc        <= '0;
      ptr         <= '0;
      rw_q        <= 1'b0;
      m_ack       <= 1'b0;
      wrote       <= 1'b0;
      readb       <= 1'b0;
      rd_cap      <= 1'b0;
      snap_cap    <= 1'b0;
      sda_oe_o    <= 1'b0;
      reg_addr_o  <= '0;
      reg_wr_o    <= 1'b0;
      reg_wdata_o <= '0;
      reg_rd_o    <= 1'b0;
      wr_done_o   <= 1'b0;
      rd_done_o   <= 1'b0;
    end else begin
      reg_wr_o  <= 1'b0;
      reg_rd_o  <= 1'b0;
      snap_cap  <= 1'b0;
      wr_done_o <= 1'b0;
      rd_done_o <= 1'b0;
      rd_cap    <= reg_rd_o;
      if (rd_cap) tx_next <= snap_hit ? snap_byte : reg_rdata_i;

      if (stop_e) begin
        state     <= ST_IDLE;
        sda_oe_o  <= 1'b0;
        wr_done_o <= wrote;
        rd_done_o <= readb;
        wrote     <= 1'b0;
        readb     <= 1'b0;
      end else if (start_e) begin
        state    <= ST_DEV;
        bitc     <= '0;
        sda_oe_o <= 1'b0;
      end else begin
        unique case (state)
          ST_DEV, ST_REG, ST_WR: begin
            if (scl_rise) begin
              rx_sh <= {rx_sh[6:0], sda_f};
              bitc  <= bitc + 4'd1;
            end else if (scl_fall && bitc == 4'd8) begin
              bitc <= '0;
              if (state == ST_DEV) begin
                if (rx_sh[7:1] == DEV_ID) begin
                  sda_oe_o <= 1'b1;
                  rw_q     <= rx_sh[0];
                  state    <= ST_ACK_DEV;
                  if (rx_sh[0]) begin
                    snap_cap   <= 1'b1;
                    reg_rd_o   <= 1'b1;
                    reg_addr_o <= ptr;
                  end
                end else begin
                  state <= ST_SKIP;
                end
              end else if (state == ST_REG) begin
                ptr      <= rx_sh[ADDR_W-1:0];
                sda_oe_o <= 1'b1;
                state    <= ST_ACK_REG;
              end else begin
                reg_wr_o    <= 1'b1;
                reg_addr_o  <= ptr;
                reg_wdata_o <= rx_sh;
                ptr         <= ptr + ADDR_W'(1);
                wrote       <= 1'b1;
                sda_oe_o    <= 1'b1;
                state       <= ST_ACK_WR;
              end
            end
          end
          ST_ACK_DEV, ST_ACK_REG, ST_ACK_WR: begin
            if (scl_fall) begin
              bitc     <= '0;
              sda_oe_o <= 1'b0;
              if (state == ST_ACK_DEV && rw_q) begin
                state    <= ST_TX;
                tx_sh    <= tx_next;
                sda_oe_o <= ~tx_next[7];
              end else if (state == ST_ACK_DEV) begin
                state <= ST_REG;
              end else begin
                state <= ST_WR;
              end
            end
          end
          ST_TX: begin
            if (scl_fall) begin
              if (bitc == 4'd7) begin
                bitc       <= '0;
                sda_oe_o   <= 1'b0;
                state      <= ST_TX_ACK;
                ptr        <= ptr + ADDR_W'(1);
                readb      <= 1'b1;
                reg_rd_o   <= 1'b1;
                reg_addr_o <= ptr + ADDR_W'(1);
              end else begin
                tx_sh    <= {tx_sh[6:0], tx_sh[7]};
                sda_oe_o <= ~tx_sh[6];
                bitc     <= bitc + 4'd1;
              end
            end
          end
          ST_TX_ACK: begin
            if (scl_rise) begin
              m_ack <= ~sda_f;
            end else if (scl_fall) begin
              if (m_ack) begin
                state    <= ST_TX;
                tx_sh    <= tx_next;
                sda_oe_o <= ~tx_next[7];
                bitc     <= '0;
              end else begin
                state <= ST_SKIP;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  // R12: drive changes happen only while the filtered SCL is low
  a_r12_drive_scl_low: assert property (@(posedge clk) disable iff (rst)
    (!$stable(sda_oe_o) && !$past(start_e) && !$past(stop_e)) |-> !scl_f);

  // R10: completion pulses appear only right after a detected STOP
  a_r10_done_after_stop: assert property (@(posedge clk) disable iff (rst)
    (wr_done_o || rd_done_o) |-> $past(stop_e));

  // R3: a byte slot never issues both a write and a read strobe
  a_r3_strobe_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(reg_wr_o && reg_rd_o));

  // R2: an ignored transaction stays silent on the bus and the back end
  a_r2_skip_silent: assert property (@(posedge clk) disable iff (rst)
    (state == ST_SKIP) |-> (!sda_oe_o && !reg_wr_o));

  // R4: every write strobe is followed by a pointer one above its address
  a_r4_ptr_step: assert property (@(posedge clk) disable iff (rst)
    reg_wr_o |-> (ptr == reg_addr_o + ADDR_W'(1)));
endmodule

// File: tb/tb_i2c_regport.sv
module tb_i2c_regport;
  localparam int AW = 5;
  localparam int NT = 7;
  localparam int Q  = 20;
  localparam logic [7:0] ID_W = 8'hDE;
  localparam logic [7:0] ID_R = 8'hDF;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst;
  logic m_scl, m_sda;
  logic sda_bus, sda_oe;
  logic [AW-1:0] reg_addr;
  logic reg_wr, reg_rd, wr_done, rd_done;
  logic [7:0] reg_wdata, rdata;
  logic [NT*8-1:0] tvec;

  assign sda_bus = m_sda & ~sda_oe;

  i2c_regport dut (
    .clk(clk), .rst(rst), .scl_i(m_scl), .sda_i(sda_bus), .sda_oe_o(sda_oe),
    .reg_addr_o(reg_addr), .reg_wr_o(reg_wr), .reg_wdata_o(reg_wdata),
    .reg_rd_o(reg_rd), .reg_rdata_i(rdata), .time_i(tvec),
    .wr_done_o(wr_done), .rd_done_o(rd_done)
  );

  logic [7:0] bmem [32];
  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 32; i++) bmem[i] <= 8'h00;
      rdata <= 8'h00;
    end else begin
      if (reg_wr) bmem[reg_addr] <= reg_wdata;
      if (reg_rd) rdata <= bmem[reg_addr];
    end
  end

  int n_wd, n_rdn, n_wstb, n_badchg;
  logic oe_prev;
  always @(posedge clk) begin
    if (rst) begin
      n_wd = 0; n_rdn = 0; n_wstb = 0; n_badchg = 0; oe_prev = 1'b0;
    end else begin
      if (wr_done) n_wd++;
      if (rd_done) n_rdn++;
      if (reg_wr) n_wstb++;
      if (sda_oe != oe_prev && m_scl) n_badchg++;
      oe_prev = sda_oe;
    end
  end

  int n_chk = 0, n_fail = 0;
  bit finished = 0;
  logic [7:0] exp_mem [32];
  logic [NT*8-1:0] snap_m;
  int ptr_m = 0, exp_wd = 0, exp_rdn = 0, exp_wstb = 0;

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  function automatic logic [7:0] exp_byte(input int a);
    int b;
    b = a % 32;
    if (b < NT) return snap_m[8*b +: 8];
    return exp_mem[b];
  endfunction

  function automatic logic [7:0] pat(input int a);
    return 8'((a * 37 + 11) & 255);
  endfunction

  task automatic i2c_start();
    m_sda = 1; m_scl = 1; wc(Q);
    m_sda = 0; wc(Q);
    m_scl = 0; wc(Q);
  endtask

  task automatic i2c_rstart();
    m_sda = 1; wc(Q);
    m_scl = 1; wc(Q);
    m_sda = 0; wc(Q);
    m_scl = 0; wc(Q);
  endtask

  task automatic i2c_stop();
    m_sda = 0; wc(Q);
    m_scl = 1; wc(Q);
    m_sda = 1; wc(Q);
  endtask

  task automatic wbyte(input logic [7:0] b, input bit glitch, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      m_sda = b[i];
      if (glitch && i == 4) begin
        wc(8); m_scl = 1; wc(3); m_scl = 0; wc(Q - 11);
      end else begin
        wc(Q);
      end
      m_scl = 1;
      if (glitch && i == 7) begin
        wc(Q); m_sda = 0; wc(3); m_sda = 1; wc(Q - 3);
      end else begin
        wc(2 * Q);
      end
      m_scl = 0; wc(Q);
    end
    m_sda = 1; wc(Q);
    m_scl = 1; wc(Q);
    ack = (sda_bus == 1'b0);
    wc(Q);
    m_scl = 0; wc(Q);
  endtask

  task automatic rbyte(input bit mack, output logic [7:0] b);
    m_sda = 1;
    for (int i = 7; i >= 0; i--) begin
      wc(Q); m_scl = 1; wc(Q);
      b[i] = sda_bus;
      wc(Q); m_scl = 0;
    end
    wc(4); m_sda = mack ? 1'b0 : 1'b1; wc(Q - 4);
    m_scl = 1; wc(2 * Q);
    m_scl = 0; wc(Q);
    m_sda = 1;
  endtask

  task automatic read_body(input int n, input int chg_at, input string tag);
    bit ack;
    logic [7:0] b;
    wbyte(ID_R, 0, ack);
    chk({tag, " R1 read id ack"}, ack, 1);
    snap_m = tvec;
    for (int k = 0; k < n; k++) begin
      rbyte(k < n - 1, b);
      chk({tag, $sformatf(" byte %0d at %0h", k, ptr_m % 32)}, b, exp_byte(ptr_m));
      ptr_m = (ptr_m + 1) % 32;
      if (k == chg_at) tvec = ~tvec;
    end
    chk({tag, " R7 released after NACK"}, sda_oe, 0);
    i2c_stop();
    exp_rdn++;
  endtask

  task automatic cur_read(input int n, input string tag);
    i2c_start();
    read_body(n, -1, tag);
  endtask

  task automatic rand_read(input int addr, input int n, input int chg_at, input string tag);
    bit ack;
    i2c_start();
    wbyte(ID_W, 0, ack);  chk({tag, " R1 id ack"}, ack, 1);
    wbyte(8'(addr), 0, ack); chk({tag, " R3 addr ack"}, ack, 1);
    ptr_m = addr;
    i2c_rstart();
    read_body(n, chg_at, tag);
  endtask

  task automatic page_write(input int addr, input int n, input bit glitch, input string tag);
    bit ack;
    int a;
    i2c_start();
    wbyte(ID_W, 0, ack);  chk({tag, " R1 id ack"}, ack, 1);
    wbyte(8'(addr), 0, ack); chk({tag, " R3 addr ack"}, ack, 1);
    a = addr;
    for (int k = 0; k < n; k++) begin
      wbyte(pat(a), glitch, ack);
      chk({tag, $sformatf(" R3 data ack %0d", k)}, ack, 1);
      exp_mem[a] = pat(a);
      a = (a + 1) % 32;
    end
    ptr_m = a;
    i2c_stop();
    exp_wd++;
    exp_wstb += n;
  endtask

  initial begin
    bit ack;
    for (int i = 0; i < 32; i++) exp_mem[i] = 8'h00;
    tvec = 56'h71_62_53_44_35_26_17;
    m_scl = 1; m_sda = 1; rst = 1;
    wc(5);
    rst = 0;
    wc(2);
    // R11 reset state
    chk("R11 sda released", sda_oe, 0);
    chk("R11 write strobe", reg_wr, 0);
    chk("R11 read strobe", reg_rd, 0);
    chk("R11 done pulses", {wr_done, rd_done}, 0);
    wc(20);

    // R5 pointer starts at 0: current read returns time byte 0
    cur_read(1, "R5 reset pointer");

    // R4 sweep: page write of all 32 locations from 5 with wrap
    page_write(5, 32, 0, "R4 sweep write");
    chk("R10 write done pulses", n_wd, exp_wd);

    // R5 current-address read continues at 5 (time bytes 5,6 then 7)
    cur_read(3, "R5 current read");

    // R6 random read of 33 bytes from 0x10 wrapping through 31 to 0x10
    rand_read(16, 33, -1, "R6 R4 sequential");
    chk("R10 no write pulse from address phase", n_wd, exp_wd);
    chk("R10 read done pulses", n_rdn, exp_rdn);

    // R2 non-matching identifier
    i2c_start();
    wbyte(8'hDC, 0, ack); chk("R2 wrong id no ack", ack, 0);
    wbyte(8'h1A, 0, ack); chk("R2 later byte no ack", ack, 0);
    wbyte(8'h99, 0, ack); chk("R2 data byte no ack", ack, 0);
    i2c_stop();
    chk("R2 no write strobes", n_wstb, exp_wstb);
    chk("R2 no done pulse", n_wd, exp_wd);
    cur_read(1, "R2 pointer untouched");

    // R8 snapshot: time input changes after the first byte
    rand_read(0, 4, 0, "R8 snapshot");
    cur_read(1, "R8 fresh snapshot");

    // R9 glitches on SCL (low phase) and SDA (high phase)
    page_write(20, 1, 1, "R9 glitch write");
    chk("R9 one strobe", n_wstb, exp_wstb);
    rand_read(20, 1, -1, "R9 readback");

    chk("R10 final write pulses", n_wd, exp_wd);
    chk("R10 final read pulses", n_rdn, exp_rdn);
    chk("R12 drive changed with SCL high", n_badchg, 0);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule